// File: doc/BRIEF.md
# Converter Result Bus Read Interface

This block is the host-facing read port of a sampling converter. Each time the converter core signals a finished conversion, the block captures the sample into an output buffer and stores it left-justified in a 16-bit word. A host reads the port with a chip select and a read strobe. One address bit chooses between a status byte and the conversion data. The resolution is fixed by a parameter and can be 12, 14 or 16 bits.

A bus-width input chooses how data reads are served. When the input is high, the whole result appears at once on the 16 lines. When it is low, the result comes out as two bytes on the low 8 lines over two reads. The first read returns the most significant byte and the second returns the rest. The pointer then keeps alternating between the two bytes until a new result arrives. The status byte carries an active-low end-of-conversion flag, the next-byte pointer, an active-low settled flag and the three live activity flags of the core.

The pin electrical behaviour is not modelled. Each output line is a value plus a per-line drive enable, and an enable of 0 stands for high impedance. Internal state (the flag and the pointer) changes once per read, on the cycle after the strobe is released.

Top module: `res_rdport`

## Requirements
- R1: With `sel` and `rd` high and `addr` = 0, lines 7..0 carry the status byte and are enabled, and lines 15..8 are not enabled (`oe` = 16'h00FF).
- R2: Status byte layout: bit 0 is the end-of-conversion flag, bit 1 and bit 4 read 0, bit 2 is the byte pointer, bit 3 is the inverse of `settled`, and bits 5, 6, 7 equal `trk`, `conv`, `cal`.
- R3: Status bit 0 is 1 after reset. It becomes 0 on the clock edge where `done` is sampled high. It returns to 1 at the end of the first later read (status or data), one clock after `sel`/`rd` deassert.
- R4: A data read (`addr` = 1) with `wide` = 1 enables lines 15 down to 16-RES_BITS and drives them with the result, MSB on line 15. Lines below 16-RES_BITS are not enabled.
- R5: A data read with `wide` = 0 and the pointer at 0 drives the result's top 8 bits on lines 7..0 (`oe` = 16'h00FF).
- R6: A data read with `wide` = 0 and the pointer at 1 drives the remaining RES_BITS-8 bits on lines 7..0, MSB-aligned, followed by 16-RES_BITS trailing zeros.
- R7: Each completed data read with `wide` = 0 toggles the pointer (0 = high byte next, 1 = low byte next). Status bit 2 reports the pointer.
- R8: A new result (`done`) sets the pointer to 0.
- R9: If `done` arrives in the same cycle as the end of a read, the new sample is stored, bit 0 becomes 0 and the pointer becomes 0.
- R10: When `sel` and `rd` are not both high, `oe` is 0 on all 16 lines.
- R11: Status reads and data reads with `wide` = 1 leave the pointer unchanged.
- R12: After reset the stored result is 0 and the pointer is 0.
- R13: The stored result changes only on `done`. Any number of reads while `conv` is high return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| addr | input | 1 | 0 = status byte, 1 = data |
| wide | input | 1 | 1 = 16-bit data read, 0 = two-read byte sequence |
| done | input | 1 | One-cycle conversion-complete pulse |
| sample | input | RES_BITS | Finished sample, valid with `done` |
| trk | input | 1 | Core is tracking the input |
| conv | input | 1 | Core is converting |
| cal | input | 1 | Core is calibrating |
| settled | input | 1 | Acquisition has settled |
| dout | output | 16 | Bus line values |
| oe | output | 16 | Per-line drive enable, 0 = high impedance |

## Verification
The assertions assume that `done` is a single-cycle pulse. They also assume that `sel`, `rd`, `addr` and `wide` do not change in the middle of a read strobe, so each strobe maps to exactly one trailing edge. The bench changes these inputs only on falling clock edges. It holds them for the whole strobe and inserts an idle cycle between reads. It asserts `done` on its own in every case except the directed collision test, where it deliberately coincides with a strobe release. The bench drives three instances with 12, 14 and 16 bits in parallel, so every resolution sees the same pattern in both bus widths.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    // registered state of the read port
    typedef struct packed {
        logic [BUS_W-1:0] res;      // left-justified result
        logic             eoc_n;    // active-low conversion-finished flag
        logic             ptr;      // 0: high byte next, 1: low byte next
        logic             rd_act;   // read strobe seen last cycle
        logic             rd_addr;  // address latched during the strobe
        logic             rd_wide;  // width latched during the strobe
    } rdst_t;

endpackage

// File: rtl/rdport_state.sv
module rdport_state
    import rdport_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [RES_BITS-1:0] sample,
    input  logic                rd_act,
    input  logic                addr,
    input  logic                wide,
    output logic [BUS_W-1:0]    res_q,
    output logic                eoc_n_q,
    output logic                ptr_q
);

    localparam int PAD = BUS_W - RES_BITS;

    rdst_t st_d, st_q;
    logic  rd_end;

    always_comb begin
        st_d        = st_q;
        st_d.rd_act = rd_act;
        if (rd_act) begin
            st_d.rd_addr = addr;
            st_d.rd_wide = wide;
        end
        rd_end = st_q.rd_act && !rd_act;
        if (rd_end) begin
            st_d.eoc_n = 1'b1;
            if (st_q.rd_addr && !st_q.rd_wide) begin
                st_d.ptr = ~st_q.ptr;
            end
        end
        // a fresh result takes priority over the end of a read
        if (done) begin
            st_d.res   = BUS_W'(sample) << PAD;
            st_d.eoc_n = 1'b0;
            st_d.ptr   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{res: '0, eoc_n: 1'b1, ptr: 1'b0,
                      rd_act: 1'b0, rd_addr: 1'b0, rd_wide: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign eoc_n_q = st_q.eoc_n;
    assign ptr_q   = st_q.ptr;

endmodule

// File: rtl/rdport_fmt.sv
module rdport_fmt
    import rdport_pkg::*;
(
    input  logic              eoc_n,
    input  logic              ptr,
    input  logic              trk,
    input  logic              conv,
    input  logic              cal,
    input  logic              settled,
    output logic [BYTE_W-1:0] status
);

    always_comb begin
        status    = '0;
        status[0] = eoc_n;
        status[2] = ptr;
        status[3] = ~settled;
        status[5] = trk;
        status[6] = conv;
        status[7] = cal;
    end

endmodule

// File: rtl/rdport_drive.sv
module rdport_drive
    import rdport_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic              rd_act,
    input  logic              addr,
    input  logic              wide,
    input  logic              ptr,
    input  logic [BYTE_W-1:0] status,
    input  logic [BUS_W-1:0]  res,
    output logic [BUS_W-1:0]  dout,
    output logic [BUS_W-1:0]  oe
);

    localparam int PAD = BUS_W - RES_BITS;

    logic [BUS_W-1:0] wmask;

    for (genvar i = 0; i < BUS_W; i++) begin : g_wmask
        assign wmask[i] = (i >= PAD);
    end

    always_comb begin
        dout = '0;
        oe   = '0;
        if (rd_act) begin
            if (!addr) begin
                dout[BYTE_W-1:0] = status;
                oe[BYTE_W-1:0]   = '1;
            end else if (wide) begin
                dout = res & wmask;
                oe   = wmask;
            end else begin
                dout[BYTE_W-1:0] = ptr ? res[BYTE_W-1:0] : res[BUS_W-1:BYTE_W];
                oe[BYTE_W-1:0]   = '1;
            end
        end
    end

endmodule

// File: rtl/res_rdport.sv
module res_rdport
    import rdport_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                rd,
    input  logic                addr,
    input  logic                wide,
    input  logic                done,
    input  logic [RES_BITS-1:0] sample,
    input  logic                trk,
    input  logic                conv,
    input  logic                cal,
    input  logic                settled,
    output logic [15:0]         dout,
    output logic [15:0]         oe
);

    logic              rd_act;
    logic [BUS_W-1:0]  res_q;
    logic              eoc_n_q;
    logic              ptr_q;
    logic [BYTE_W-1:0] status;

    assign rd_act = sel && rd;

    rdport_state #(.RES_BITS(RES_BITS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (done),
        .sample  (sample),
        .rd_act  (rd_act),
        .addr    (addr),
        .wide    (wide),
        .res_q   (res_q),
        .eoc_n_q (eoc_n_q),
        .ptr_q   (ptr_q)
    );

    rdport_fmt u_fmt (
        .eoc_n   (eoc_n_q),
        .ptr     (ptr_q),
        .trk     (trk),
        .conv    (conv),
        .cal     (cal),
        .settled (settled),
        .status  (status)
    );

    rdport_drive #(.RES_BITS(RES_BITS)) u_drive (
        .rd_act (rd_act),
        .addr   (addr),
        .wide   (wide),
        .ptr    (ptr_q),
        .status (status),
        .res    (res_q),
        .dout   (dout),
        .oe     (oe)
    );

endmodule

// File: rtl/rdport_chk.sv
module rdport_chk #(
    parameter int RES_BITS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        rd,
    input logic        addr,
    input logic        wide,
    input logic        done,
    input logic [15:0] dout,
    input logic [15:0] oe,
    input logic [15:0] res_q,
    input logic        eoc_n_q,
    input logic        ptr_q
);

    localparam int PAD = 16 - RES_BITS;
    localparam logic [15:0] WIDE_OE = ~((16'h1 << PAD) - 16'h1);

    logic act_q;
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= sel && rd;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd) |-> oe == 16'h0000); // R10
    AST_STATUS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && !addr) |-> oe == 16'h00FF); // R1
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && !addr) |-> (dout[1] == 1'b0 && dout[4] == 1'b0)); // R2
    AST_WIDE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr && wide) |-> oe == WIDE_OE); // R4
    AST_NARROW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr && !wide) |-> oe == 16'h00FF); // R5
    AST_EOC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !eoc_n_q); // R3
    AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !(sel && rd) && !done) |=> eoc_n_q); // R3
    AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !ptr_q); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(res_q)); // R13

endmodule

bind res_rdport rdport_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .rd      (rd),
    .addr    (addr),
    .wide    (wide),
    .done    (done),
    .dout    (dout),
    .oe      (oe),
    .res_q   (res_q),
    .eoc_n_q (eoc_n_q),
    .ptr_q   (ptr_q)
);

// File: tb/res_rdport_tb_top.sv
module res_rdport_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n, sel, rd, addr, wide, done, trk, conv, cal, settled;
    logic [15:0] smp;
    logic [15:0] dout_w [3];
    logic [15:0] oe_w   [3];

    for (genvar k = 0; k < 3; k++) begin : g_res
        localparam int R = 12 + 2 * k;
        res_rdport #(.RES_BITS(R)) dut_i (
            .clk (clk), .rst_n (rst_n), .sel (sel), .rd (rd),
            .addr (addr), .wide (wide), .done (done),
            .sample (smp[15 -: R]),
            .trk (trk), .conv (conv), .cal (cal), .settled (settled),
            .dout (dout_w[k]), .oe (oe_w[k])
        );
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model
    logic        eoc_m;
    logic        ptr_m;
    logic [15:0] val_m;

    // stimulus table: {sample, wide flag for data reads, number of data reads}
    localparam logic [20:0] VEC [6] = '{
        {16'hA5C3, 1'b0, 4'd3},
        {16'hFFFF, 1'b0, 4'd4},
        {16'h1234, 1'b1, 4'd2},
        {16'h8001, 1'b0, 4'd5},
        {16'h7E5A, 1'b1, 4'd1},
        {16'h0F0F, 1'b0, 4'd2}
    };

    function automatic logic [15:0] mask_of(int k);
        return 16'hFFFF << (4 - 2 * k);
    endfunction

    task automatic chk(string tag, int k, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s res=%0d actual=%h expected=%h", tag, 12 + 2 * k, act, exp);
        end
    endtask

    task automatic do_read(logic a, logic w);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a; wide = w;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] m = val_m & mask_of(k);
            if (!a) begin
                logic [7:0] st = {cal, conv, trk, 1'b0, ~settled, ptr_m, 1'b0, eoc_m};
                chk("R1 status lanes", k, oe_w[k], 16'h00FF);
                chk("R2 R3 status byte", k, {8'h00, dout_w[k][7:0]}, {8'h00, st});
            end else if (w) begin
                chk("R4 wide lanes", k, oe_w[k], mask_of(k));
                chk("R4 R13 wide data", k, dout_w[k] & oe_w[k], m);
            end else begin
                chk("R5 R6 narrow lanes", k, oe_w[k], 16'h00FF);
                chk(ptr_m ? "R6 low byte" : "R5 high byte", k,
                    {8'h00, dout_w[k][7:0]}, {8'h00, ptr_m ? m[7:0] : m[15:8]});
            end
        end
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
        @(negedge clk);
        eoc_m = 1'b1;
        if (a && !w) ptr_m = ~ptr_m;
    endtask

    task automatic new_sample(logic [15:0] s);
        @(negedge clk);
        done = 1'b1; smp = s;
        @(negedge clk);
        done = 1'b0;
        val_m = s; eoc_m = 1'b0; ptr_m = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel = 1'b0; rd = 1'b0; addr = 1'b0; wide = 1'b0;
        done = 1'b0; smp = '0; trk = 1'b0; conv = 1'b0; cal = 1'b0; settled = 1'b0;
        eoc_m = 1'b1; ptr_m = 1'b0; val_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 / R12: idle bus and reset state
        for (int k = 0; k < 3; k++) chk("R10 idle oe", k, oe_w[k], 16'h0000);
        do_read(1'b0, 1'b0);          // R12 status after reset
        do_read(1'b1, 1'b1);          // R12 result zero

        // table walk
        for (int v = 0; v < 6; v++) begin
            trk = v[0]; conv = v[1]; cal = v[2]; settled = ~v[0];
            new_sample(VEC[v][20:5]);
            do_read(1'b0, 1'b0);                         // R3 flag low
            for (int r = 0; r < int'(VEC[v][3:0]); r++)
                do_read(1'b1, VEC[v][4]);                // R5 R6 R7 toggling
            do_read(1'b0, 1'b0);                         // R3 cleared, R7 pointer
        end

        // R3: a data read as the first read also clears the flag
        new_sample(16'h4C2B);
        do_read(1'b1, 1'b0);
        do_read(1'b0, 1'b0);

        // R11: status and wide reads leave the pointer at 1
        do_read(1'b1, 1'b1);
        do_read(1'b0, 1'b0);
        do_read(1'b1, 1'b0);          // low byte expected (R11)

        // R8: new result sends the pointer back home
        do_read(1'b1, 1'b0);          // pointer now 1
        new_sample(16'h9ABC);
        do_read(1'b0, 1'b0);          // R8 bit2 = 0
        do_read(1'b1, 1'b0);          // R8 high byte

        // R9: done collides with end of a read
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = 1'b1; wide = 1'b0;
        @(negedge clk);
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; done = 1'b1; smp = 16'h3D71;
        @(negedge clk);
        done = 1'b0;
        val_m = 16'h3D71; eoc_m = 1'b0; ptr_m = 1'b0;
        do_read(1'b0, 1'b0);          // R9 flag low, pointer 0
        do_read(1'b1, 1'b0);          // R9 new high byte

        // R13: repeated reads during conversion return the same result
        conv = 1'b1;
        for (int r = 0; r < 3; r++) do_read(1'b1, 1'b1);
        conv = 1'b0;
        for (int k = 0; k < 3; k++) chk("R10 idle oe end", k, oe_w[k], 16'h0000);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule